// File: doc/BRIEF.md
# Segmented Packet Bus Packer

This block takes a packet stream one 128-bit beat at a time and repacks it onto a wide bus. The wide bus is made of four 128-bit lanes that are presented together in a single clock cycle. The input side uses a valid/ready handshake. Each input beat carries a last flag, an error flag and a count of unused bytes.

Each output lane has its own enable and its own framing controls: start of packet, end of packet, error and a 4-bit unused-byte count. A packet can therefore close in any lane, and the next packet opens in the lane directly after it, so no lane is wasted at a packet tail.

Beats fill the lanes in arrival order, starting at lane 0. A wide word is released when all four lanes are filled. It is also released early when no input beat is offered and at least one lane holds data. One ready input on the wide side stalls the whole path.

Top module: `seg_packer`

## Requirements
- R1: After reset all lane enables are 0, and the first accepted beat is marked as a start of packet.
- R2: When the fourth beat of a word is accepted, the next clock edge presents a word with all four lane enables set (pattern 4'b1111). Lane 0 holds the earliest beat and lane 3 the latest.
- R3: A partial word of n lanes (1 to 3) is released on the first edge at which the wide-side ready is 1 and no input beat is valid. Its enables are the low n bits set and the upper bits clear.
- R4: Start of packet is 1 only on the first beat of a packet, and end of packet is 1 only on the beat that carried the last flag. A new packet can start in the lane that follows the lane that ended the previous packet, within the same word.
- R5: On an end-of-packet lane without error, the unused-byte count equals the input count. On a lane that does not end a packet, the error flag and the unused-byte count are 0.
- R6: On an end-of-packet lane whose input error flag was set, the lane error is 1. The low three bits of the unused-byte count are 000 and bit 3 keeps the input value. An error flag on a beat that is not last is ignored (lane error 0).
- R7: While the wide-side ready is 0, the input ready is 0, and every output holds its value on the next edge.
- R8: A released word is shown for one cycle when the wide-side ready is 1. It is followed by all enables 0 unless another word is released on that edge.
- R9: On any lane whose enable is 0, the start, end, error and unused-byte outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 128 | Input beat data |
| s_valid | input | 1 | Input beat offered |
| s_ready | output | 1 | Input beat taken on this edge if valid |
| s_last | input | 1 | Beat ends its packet |
| s_err | input | 1 | Packet is bad (used with s_last) |
| s_empty | input | 4 | Unused bytes in a last beat |
| seg_data | output | 512 | Lane data, lane i at bits [128*i+127:128*i] |
| seg_ena | output | 4 | Per-lane enable |
| seg_sop | output | 4 | Per-lane start of packet |
| seg_eop | output | 4 | Per-lane end of packet |
| seg_err | output | 4 | Per-lane error |
| seg_empty | output | 16 | Per-lane unused-byte count, lane i at bits [4*i+3:4*i] |
| seg_ready | input | 1 | Wide side accepts the presented word |

## Verification
Several properties are checked on every cycle:
- Enables stay contiguous from lane 0.
- Idle lanes stay quiet.
- Error lanes zero the low empty bits.
- Non-final lanes carry no error or count.
- A stalled word holds still.
- The fourth accepted beat yields a full word.

Other behaviour needs whole scenarios to show it:
- The lane-to-beat order and the data content.
- The start and end marks across packet boundaries inside one word.
- The exact edge at which a partial word is flushed.
- That an error on a non-final beat is dropped.

The bench predicts each of these from its own model of the packing.

// File: rtl/seg_packer.sv
module seg_packer #(
  parameter int SEG_W = 128,
  parameter int NSEG  = 4,
  parameter int MTY_W = $clog2(SEG_W / 8)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SEG_W-1:0]        s_data,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic                    s_last,
  input  logic                    s_err,
  input  logic [MTY_W-1:0]        s_empty,
  output logic [NSEG*SEG_W-1:0]   seg_data,
  output logic [NSEG-1:0]         seg_ena,
  output logic [NSEG-1:0]         seg_sop,
  output logic [NSEG-1:0]         seg_eop,
  output logic [NSEG-1:0]         seg_err,
  output logic [NSEG*MTY_W-1:0]   seg_empty,
  input  logic                    seg_ready
);
  localparam int CNT_W = $clog2(NSEG + 1);
  localparam int CTL_W = MTY_W + 3;

  logic [CNT_W-1:0] fill;
  logic             in_pkt;
  logic [CTL_W-1:0] beat_ctl;

  assign s_ready = seg_ready;

  wire take     = s_valid && s_ready;
  wire full_go  = take && (fill == CNT_W'(NSEG - 1));
  wire flush_go = seg_ready && !s_valid && (fill != '0);
  wire load     = full_go || flush_go;

  assign beat_ctl = {!in_pkt, s_last, s_last & s_err,
                     s_last ? (s_err ? {s_empty[MTY_W-1], {(MTY_W-1){1'b0}}} : s_empty)
                            : {MTY_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill   <= '0;
      in_pkt <= 1'b0;
    end else begin
      if (take) in_pkt <= !s_last;
      if (load) fill <= '0;
      else if (take) fill <= fill + 1'b1;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_lane
    logic [SEG_W-1:0] acc_d, o_d;
    logic [CTL_W-1:0] acc_c, o_c;
    logic             o_en;

    wire from_acc = fill > CNT_W'(i);
    wire from_in  = full_go && (i == NSEG - 1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_d <= '0;
        acc_c <= '0;
      end else if (take && !full_go && fill == CNT_W'(i)) begin
        acc_d <= s_data;
        acc_c <= beat_ctl;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o_en <= 1'b0;
        o_d  <= '0;
        o_c  <= '0;
      end else if (seg_ready) begin
        if (load && (from_acc || from_in)) begin
          o_en <= 1'b1;
          o_d  <= from_in ? s_data : acc_d;
          o_c  <= from_in ? beat_ctl : acc_c;
        end else begin
          o_en <= 1'b0;
          o_d  <= '0;
          o_c  <= '0;
        end
      end
    end

    assign seg_data[i*SEG_W +: SEG_W]   = o_d;
    assign seg_ena[i]                   = o_en;
    assign seg_sop[i]                   = o_c[CTL_W-1];
    assign seg_eop[i]                   = o_c[CTL_W-2];
    assign seg_err[i]                   = o_c[CTL_W-3];
    assign seg_empty[i*MTY_W +: MTY_W]  = o_c[MTY_W-1:0];

    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_ena[i] && seg_err[i]) |-> (seg_empty[i*MTY_W +: MTY_W-1] == '0)); // R6
    AST_NONFINAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_ena[i] && !seg_eop[i]) |-> (!seg_err[i] && seg_empty[i*MTY_W +: MTY_W] == '0)); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_ena[i] |-> !(seg_sop[i] || seg_eop[i] || seg_err[i] || |seg_empty[i*MTY_W +: MTY_W])); // R9
  end

  AST_ENA_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_ena & NSEG'(seg_ena + 1'b1)) == '0); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_ready |=> ($stable(seg_ena) && $stable(seg_data) && $stable(seg_sop)
                    && $stable(seg_eop) && $stable(seg_err) && $stable(seg_empty))); // R7
  AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && fill == CNT_W'(NSEG - 1)) |=> (&seg_ena)); // R2
endmodule

// File: tb/seg_packer_bench.sv
module seg_packer_bench;
  localparam int CLK_P = 10;
  localparam int NS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [127:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0, seg_ready = 1'b0;
  logic [3:0] s_empty = '0;
  logic s_ready;
  logic [511:0] seg_data;
  logic [3:0] seg_ena, seg_sop, seg_eop, seg_err;
  logic [15:0] seg_empty;

  seg_packer u_seg_packer (.clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_last(s_last), .s_err(s_err), .s_empty(s_empty),
    .seg_data(seg_data), .seg_ena(seg_ena), .seg_sop(seg_sop), .seg_eop(seg_eop),
    .seg_err(seg_err), .seg_empty(seg_empty), .seg_ready(seg_ready));

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [127:0] q_d[$];
  logic [6:0]   q_c[$];
  int pred = 0, pn = 0, mcnt = 0;   // pred: 0 clear, 1 load pn lanes, 2 hold
  bit mid = 0;
  logic [511:0] p_data; logic [3:0] p_ena, p_sop, p_eop, p_err; logic [15:0] p_emp;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_ctl(bit sop, bit last, bit err, logic [3:0] e);
    logic [3:0] em = !last ? 4'd0 : (err ? {e[3], 3'b000} : e);
    return {sop, last, last & err, em};
  endfunction

  task automatic observe();
    if (pred == 2) begin
      chk(seg_data == p_data && seg_ena == p_ena && seg_sop == p_sop && seg_eop == p_eop
          && seg_err == p_err && seg_empty == p_emp, "R7 hold", {124'd0, seg_ena}, {124'd0, p_ena});
    end else begin
      logic [3:0] m = (pred == 1) ? 4'((1 << pn) - 1) : 4'd0;
      chk(seg_ena == m, (pred == 0) ? "R8 enables" : (pn == NS ? "R2 enables" : "R3 enables"),
          {124'd0, seg_ena}, {124'd0, m});
      for (int i = 0; i < NS; i++) begin
        if (m[i]) begin
          logic [127:0] ed; logic [6:0] ec;
          if (q_d.size() == 0) begin chk(0, "R2 queue", 0, 1); continue; end
          ed = q_d.pop_front(); ec = q_c.pop_front();
          chk(seg_data[i*128 +: 128] == ed, "R2 data", seg_data[i*128 +: 128], ed);
          chk(seg_sop[i] == ec[6], "R4 sop", {127'd0, seg_sop[i]}, {127'd0, ec[6]});
          chk(seg_eop[i] == ec[5], "R4 eop", {127'd0, seg_eop[i]}, {127'd0, ec[5]});
          chk(seg_err[i] == ec[4], "R6 err", {127'd0, seg_err[i]}, {127'd0, ec[4]});
          chk(seg_empty[i*4 +: 4] == ec[3:0], "R5 empty", {124'd0, seg_empty[i*4 +: 4]}, {124'd0, ec[3:0]});
        end else begin
          chk({seg_sop[i], seg_eop[i], seg_err[i], seg_empty[i*4 +: 4]} == 7'd0, "R9 idle lane",
              {121'd0, seg_sop[i], seg_eop[i], seg_err[i], seg_empty[i*4 +: 4]}, 0);
        end
      end
    end
    p_data = seg_data; p_ena = seg_ena; p_sop = seg_sop; p_eop = seg_eop; p_err = seg_err; p_emp = seg_empty;
  endtask

  task automatic step(bit v, bit last, bit err, logic [3:0] e, logic [127:0] d, bit rdy);
    bit acc;
    @(negedge clk);
    observe();
    s_valid = v; s_last = last; s_err = err; s_empty = e; s_data = d; seg_ready = rdy;
    #1;
    chk(s_ready == rdy, "R7 in ready", {127'd0, s_ready}, {127'd0, rdy});
    acc = v && rdy;
    if (acc) begin
      q_d.push_back(d); q_c.push_back(exp_ctl(!mid, last, err, e));
      mid = !last;
    end
    if (!rdy) pred = 2;
    else if (acc && mcnt == NS - 1) begin pred = 1; pn = NS; mcnt = 0; end
    else if (!v && mcnt != 0) begin pred = 1; pn = mcnt; mcnt = 0; end
    else begin pred = 0; if (acc) mcnt++; end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * CLK_P);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; seg_ready = 1'b1;
    @(negedge clk);
    chk(seg_ena == 4'd0, "R1 reset enables", {124'd0, seg_ena}, 0);
    p_data = seg_data; p_ena = seg_ena; p_sop = seg_sop; p_eop = seg_eop; p_err = seg_err; p_emp = seg_empty;
    // R1/R3/R5: single-beat packet then idle flush
    step(1, 1, 0, 4'd5, 128'hA1, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R6: error on last, empty bits masked
    step(1, 0, 1, 4'd3, 128'hB1, 1);
    step(1, 1, 1, 4'hF, 128'hB2, 1);
    step(1, 1, 0, 4'd7, 128'hB3, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    // R4: packet ends in lane 1, next begins lane 2
    step(1, 0, 0, 0, 128'hC1, 1);
    step(1, 1, 0, 4'd2, 128'hC2, 1);
    step(1, 0, 0, 0, 128'hC3, 1);
    step(1, 0, 0, 0, 128'hC4, 1);
    step(1, 1, 0, 4'd9, 128'hC5, 1);
    step(0, 0, 0, 0, 0, 1);
    // R7: stall with a pending word
    step(1, 0, 0, 0, 128'hD1, 1);
    step(1, 0, 0, 0, 128'hD2, 1);
    step(1, 0, 0, 0, 128'hD3, 1);
    step(1, 1, 0, 4'd1, 128'hD4, 1);
    step(1, 0, 0, 0, 128'hD5, 0);
    step(1, 0, 0, 0, 128'hD6, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 4000; k++) begin
      bit v = ($urandom % 4) != 0;
      bit r = ($urandom % 5) != 0;
      step(v, ($urandom % 3) == 0, ($urandom % 4) == 0, 4'($urandom), rnd128(), r);
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk(q_d.size() == 0, "R2 drained", q_d.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule